// File: doc/BRIEF.md
# Frame-Aligned Camera Capture Interface

This block receives pixel samples from a parallel image sensor. The sensor drives an 8-bit data bus and two strobes, one marking the frame and one marking the line, on the pixel clock that also clocks this block. The block packs the samples into 32-bit words. It sends them out on a valid/ready stream, with a start-of-frame marker on the first word of each frame and an end-of-line marker on the last word of each line. The two strobes are the only source of timing; no sync codes are embedded in the data.

Setting the enable input does not start capture straight away. The block first waits until it sees the frame strobe low, and only then arms for the next rising edge of that strobe. If enable is raised while a frame is already running, that frame is skipped as a whole. Capture therefore never begins partway through a frame, which would give a shifted and distorted image.

Two programmed limits bound each frame. One caps the number of samples kept per line. The other is programmed to the wanted line count plus one and caps the number of lines kept. A frame-done pulse reports the end of every frame that was captured. A sticky flag reports words that were lost because the downstream consumer stalled.

Top module: `camCapture`

## Requirements
- R1: After enable goes high, no word is produced until frameValid has been seen low. Capture then starts at the next rising edge of frameValid. A frame already in progress when enable rises produces no words and no frameDone pulse.
- R2: frameValid and lineValid each pass through one register stage before use. A sample is taken only while both are high inside an armed frame. Data on pixData while frameValid is low produces no words.
- R3: Four samples taken one after another form one 32-bit word. The first sample goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R4: At most lineLimit samples are kept from each lineValid period, and the rest of that line is dropped. With lineLimit = 1280, a line of 640 two-sample pixels gives exactly 320 words.
- R5: If a line ends with 1 to 3 samples not yet packed, they are sent as one word. Their byte lanes are filled from bit 0 upward and the unused upper lanes are zero.
- R6: outEol is 1 on the last word of each line and 0 on every other word. outSof is 1 on the first word of each captured frame only.
- R7: frameLimit holds the wanted line count plus one. At most frameLimit−1 lines are captured per frame, and any later lines in that frame give no words.
- R8: While outValid is 1 and outReady is 0, outData, outSof and outEol hold steady. If the consumer stalls but frees the output before the next word is ready, no word is lost.
- R9: If a new word is ready while the output still holds a word that has not been accepted, the new word is dropped, the held word is kept, and overflow goes to 1. overflow stays at 1 until reset.
- R10: frameDone pulses high for exactly one cycle when frameValid falls at the end of a captured frame. This happens once per captured frame.
- R11: Clearing enable throws away any partly packed data and sends the block back to waiting for frameValid low. Re-enabling during a frame therefore skips the rest of that frame.
- R12: After reset, outValid, overflow and frameDone are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Capture enable |
| lineLimit | input | 16 | Maximum samples kept per line |
| frameLimit | input | 16 | Lines kept per frame, plus one |
| pixData | input | 8 | Sensor sample bus |
| frameValid | input | 1 | Sensor frame strobe, active high |
| lineValid | input | 1 | Sensor line strobe, active high |
| outData | output | 32 | Packed word |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Consumer accepts the word |
| outSof | output | 1 | First word of a frame |
| outEol | output | 1 | Last word of a line |
| overflow | output | 1 | Sticky lost-word flag |
| frameDone | output | 1 | One-cycle end-of-captured-frame pulse |

## Verification
The properties assume that the reset is held for at least two clocks with all inputs driven to known values, because the frame-done check looks two cycles back at frameValid. They also assume that lineValid rises only after frameValid has already been high for a clock, and that lineValid falls no later than frameValid, as real sensors do with their blanking. The stimulus raises frameValid three clocks before the first line, leaves gaps of several clocks between lines, and lowers frameValid only after the last line has ended. Line lengths in the stalled-consumer scenario are multiples of four, so the word rate never goes above what the toggling ready can absorb.

// File: rtl/camCapPkg.sv
package camCapPkg;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_WAIT_LOW,
    CS_ARMED,
    CS_ACTIVE
  } capState_t;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic take;        // latch the registered sample into the packer
    logic lineEnd;     // line closed: flush the pending or partial word with EOL
    logic clear;       // drop packer contents and frame marker
    logic frameStart;  // arm the start-of-frame marker
  } capStrobe_t;

endpackage

// File: rtl/camCapCtrl.sv
module camCapCtrl
  import camCapPkg::*;
#(
  parameter int SAMPLE_CNT_W = 16,
  parameter int LINE_CNT_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [SAMPLE_CNT_W-1:0] lineLimit,
  input  logic [LINE_CNT_W-1:0]   frameLimit,
  input  logic                    fvQ,
  input  logic                    lvQ,
  output capStrobe_t              strobe,
  output logic                    frameDone
);

  capState_t state, stateNext;
  logic [SAMPLE_CNT_W-1:0] sampleCount;
  logic [LINE_CNT_W-1:0]   lineCount;
  logic lvPrev;
  logic lineHasData;
  logic lineRoom;
  logic sampleRoom;
  logic isActive;

  assign isActive   = (state == CS_ACTIVE);
  assign sampleRoom = sampleCount < lineLimit;
  assign lineRoom   = ({1'b0, lineCount} + (LINE_CNT_W+1)'(1)) < {1'b0, frameLimit};

  assign strobe.take       = isActive && fvQ && lvQ && sampleRoom && lineRoom;
  assign strobe.lineEnd    = lineHasData && !lvQ;
  assign strobe.clear      = (state == CS_IDLE);
  assign strobe.frameStart = (state == CS_ARMED) && fvQ && enable;

  always_comb begin
    stateNext = state;
    if (!enable) begin
      stateNext = CS_IDLE;
    end else begin
      case (state)
        CS_IDLE:     stateNext = CS_WAIT_LOW;
        CS_WAIT_LOW: if (!fvQ) stateNext = CS_ARMED;
        CS_ARMED:    if (fvQ) stateNext = CS_ACTIVE;
        CS_ACTIVE:   if (!fvQ) stateNext = CS_ARMED;
        default:     stateNext = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= CS_IDLE;
      sampleCount <= '0;
      lineCount   <= '0;
      lvPrev      <= 1'b0;
      lineHasData <= 1'b0;
      frameDone   <= 1'b0;
    end else begin
      state     <= stateNext;
      lvPrev    <= lvQ;
      frameDone <= isActive && !fvQ && enable;

      if (!lvQ || !isActive) sampleCount <= '0;
      else if (strobe.take)  sampleCount <= sampleCount + SAMPLE_CNT_W'(1);

      if (strobe.frameStart) lineCount <= '0;
      else if (isActive && lvPrev && !lvQ && lineRoom) lineCount <= lineCount + LINE_CNT_W'(1);

      if (strobe.clear || strobe.lineEnd) lineHasData <= 1'b0;
      else if (strobe.take)               lineHasData <= 1'b1;
    end
  end

endmodule

// File: rtl/camCapPath.sv
module camCapPath
  import camCapPkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PIX_W-1:0]       pixData,
  input  logic                   frameValid,
  input  logic                   lineValid,
  input  capStrobe_t             strobe,
  input  logic                   outReady,
  output logic                   fvQ,
  output logic                   lvQ,
  output logic [PIX_W*LANES-1:0] outData,
  output logic                   outValid,
  output logic                   outSof,
  output logic                   outEol,
  output logic                   overflow
);

  localparam int WORD_W = PIX_W * LANES;
  localparam int IDX_W  = $clog2(LANES);

  logic [PIX_W-1:0]  dQ;
  logic [IDX_W-1:0]  byteIdx;
  logic [WORD_W-1:0] shiftWord;
  logic [WORD_W-1:0] holdWord;
  logic [WORD_W-1:0] packNext;
  logic              holdValid;
  logic              sofPending;
  logic              lastLane;
  logic              emitHold;
  logic              emitEnd;
  logic              emit;
  logic [WORD_W-1:0] emitWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign packNext[g*PIX_W +: PIX_W] =
      (byteIdx == IDX_W'(g)) ? dQ : shiftWord[g*PIX_W +: PIX_W];
  end

  assign lastLane = (byteIdx == IDX_W'(LANES-1));
  // a full word waits in holdWord until the line either continues or closes
  assign emitHold = strobe.take && holdValid && (byteIdx == '0);
  assign emitEnd  = strobe.lineEnd && (holdValid || (byteIdx != '0));
  assign emit     = !strobe.clear && (emitHold || emitEnd);
  assign emitWord = holdValid ? holdWord : shiftWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fvQ <= 1'b0;
      lvQ <= 1'b0;
      dQ  <= '0;
    end else begin
      fvQ <= frameValid;
      lvQ <= lineValid;
      dQ  <= pixData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      byteIdx    <= '0;
      shiftWord  <= '0;
      holdWord   <= '0;
      holdValid  <= 1'b0;
      sofPending <= 1'b0;
    end else begin
      if (emit) sofPending <= 1'b0;
      if (strobe.frameStart) sofPending <= 1'b1;

      if (strobe.take) begin
        if (emitHold) holdValid <= 1'b0;
        if (lastLane) begin
          holdWord  <= packNext;
          holdValid <= 1'b1;
          shiftWord <= '0;
          byteIdx   <= '0;
        end else begin
          shiftWord <= packNext;
          byteIdx   <= byteIdx + IDX_W'(1);
        end
      end else if (strobe.lineEnd) begin
        holdValid <= 1'b0;
        shiftWord <= '0;
        byteIdx   <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
      overflow <= 1'b0;
    end else if (emit) begin
      if (!outValid || outReady) begin
        outData  <= emitWord;
        outSof   <= sofPending;
        outEol   <= strobe.lineEnd;
        outValid <= 1'b1;
      end else begin
        overflow <= 1'b1;
      end
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/camCapture.sv
module camCapture
  import camCapPkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int LANES        = 4,
  parameter int SAMPLE_CNT_W = 16,
  parameter int LINE_CNT_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [SAMPLE_CNT_W-1:0] lineLimit,
  input  logic [LINE_CNT_W-1:0]   frameLimit,
  input  logic [PIX_W-1:0]        pixData,
  input  logic                    frameValid,
  input  logic                    lineValid,
  output logic [PIX_W*LANES-1:0]  outData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic                    outSof,
  output logic                    outEol,
  output logic                    overflow,
  output logic                    frameDone
);

  localparam int WORD_W = PIX_W * LANES;

  capStrobe_t strobe;
  logic fvQ;
  logic lvQ;

  camCapCtrl #(
    .SAMPLE_CNT_W(SAMPLE_CNT_W),
    .LINE_CNT_W  (LINE_CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .lineLimit (lineLimit),
    .frameLimit(frameLimit),
    .fvQ       (fvQ),
    .lvQ       (lvQ),
    .strobe    (strobe),
    .frameDone (frameDone)
  );

  camCapPath #(
    .PIX_W(PIX_W),
    .LANES(LANES)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .pixData   (pixData),
    .frameValid(frameValid),
    .lineValid (lineValid),
    .strobe    (strobe),
    .outReady  (outReady),
    .fvQ       (fvQ),
    .lvQ       (lvQ),
    .outData   (outData[WORD_W-1:0]),
    .outValid  (outValid),
    .outSof    (outSof),
    .outEol    (outEol),
    .overflow  (overflow)
  );

endmodule

// File: rtl/camCapture_sva.sv
module camCapture_sva #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              frameValid,
  input logic [WORD_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input logic              outSof,
  input logic              outEol,
  input logic              overflow,
  input logic              frameDone
);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSof) && $stable(outEol)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R9

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(outValid && !outReady)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R10

  AST_DONE_AFTER_FV_LOW: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !$past(frameValid, 2)); // R10

  AST_DONE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(enable)); // R11

endmodule

bind camCapture camCapture_sva #(.WORD_W(WORD_W)) u_camCaptureSva (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .frameValid(frameValid),
  .outData   (outData),
  .outValid  (outValid),
  .outReady  (outReady),
  .outSof    (outSof),
  .outEol    (outEol),
  .overflow  (overflow),
  .frameDone (frameDone)
);

// File: tb/camCapture_bench.sv
module camCapture_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_GAP   = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [15:0] lineLimit;
  logic [15:0] frameLimit;
  logic [7:0]  pixData;
  logic        frameValid;
  logic        lineValid;
  logic [31:0] outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        outSof;
  logic        outEol;
  logic        overflow;
  logic        frameDone;

  logic [33:0] gotQ[$];
  logic [33:0] expQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  int doneCount = 0;
  int readyMode = 0;

  camCapture u_camCapture (
    .clk(clk), .rstN(rstN), .enable(enable), .lineLimit(lineLimit),
    .frameLimit(frameLimit), .pixData(pixData), .frameValid(frameValid),
    .lineValid(lineValid), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outSof(outSof), .outEol(outEol),
    .overflow(overflow), .frameDone(frameDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Consumer model and observation, away from the active edge
  always @(negedge clk) begin
    case (readyMode)
      0:       outReady = 1'b1;
      1:       outReady = ~outReady;
      default: outReady = 1'b0;
    endcase
    if (rstN === 1'b1 && outValid && outReady) gotQ.push_back({outSof, outEol, outData});
    if (rstN === 1'b1 && frameDone) doneCount++;
  end

  function automatic logic [7:0] pix(int f, int l, int i);
    return 8'(f * 37 + l * 11 + i * 3 + 1);
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compareStream(string req);
    int bad = -1;
    check(req, "word count", gotQ.size(), expQ.size());
    for (int k = 0; k < gotQ.size() && k < expQ.size(); k++)
      if (bad < 0 && gotQ[k] !== expQ[k]) bad = k;
    testsRun++;
    if (bad >= 0) begin
      testsFailed++;
      $display("FAIL %s word %0d: actual %0h expected %0h", req, bad, gotQ[bad], expQ[bad]);
    end
    gotQ.delete();
    expQ.delete();
  endtask

  task automatic addExpected(int f, int nLines, int nSamp, int lineLim, int frameLim);
    int capLines = (nLines < frameLim - 1) ? nLines : frameLim - 1;
    int n = (nSamp < lineLim) ? nSamp : lineLim;
    bit first = 1'b1;
    for (int l = 0; l < capLines; l++) begin
      int nWords = (n + 3) / 4;
      for (int w = 0; w < nWords; w++) begin
        logic [31:0] word = '0;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < n) word[b*8 +: 8] = pix(f, l, w * 4 + b);
        expQ.push_back({first, (w == nWords - 1), word});
        first = 1'b0;
      end
    end
  endtask

  task automatic sendLine(int f, int l, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lineValid = 1'b1;
      pixData   = pix(f, l, i);
    end
    @(negedge clk);
    lineValid = 1'b0;
    pixData   = '0;
    repeat (LINE_GAP) @(negedge clk);
  endtask

  task automatic sendFrame(int f, int nLines, int nSamp);
    @(negedge clk);
    frameValid = 1'b1;
    repeat (3) @(negedge clk);
    for (int l = 0; l < nLines; l++) sendLine(f, l, nSamp);
    frameValid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; enable = 1'b0; frameValid = 1'b0; lineValid = 1'b0;
    pixData = '0; readyMode = 0; lineLimit = 16'd8; frameLimit = 16'd4;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    gotQ.delete(); expQ.delete(); doneCount = 0;
  endtask

  task automatic testReset();
    doReset();
    check("R12", "outValid after reset", outValid, 0);
    check("R12", "overflow after reset", overflow, 0);
    check("R12", "frameDone after reset", frameDone, 0);
  endtask

  task automatic testMidFrameEnable();
    doReset();
    frameValid = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    sendLine(90, 0, 8);
    sendLine(90, 1, 8);
    frameValid = 1'b0;
    repeat (8) @(negedge clk);
    check("R1", "no words from frame in progress", gotQ.size(), 0);
    addExpected(1, 3, 8, 8, 4);
    sendFrame(1, 3, 8);
    if (gotQ.size() >= 2) begin
      check("R3", "lane order of first word", gotQ[0][31:0],
            {pix(1, 0, 3), pix(1, 0, 2), pix(1, 0, 1), pix(1, 0, 0)});
      check("R6", "sof and eol on first word", gotQ[0][33:32], 2'b10);
      check("R6", "sof and eol on second word", gotQ[1][33:32], 2'b01);
    end
    compareStream("R1");
    check("R1", "frameDone count", doneCount, 1);
  endtask

  task automatic testPartial();
    doReset();
    lineLimit = 16'd100; frameLimit = 16'd3; enable = 1'b1;
    addExpected(2, 2, 6, 100, 3);
    sendFrame(2, 2, 6);
    if (gotQ.size() >= 2)
      check("R5", "zero padded tail word", gotQ[1], {2'b01, 16'h0, pix(2, 0, 5), pix(2, 0, 4)});
    compareStream("R5");
    sendLine(3, 0, 8);
    repeat (6) @(negedge clk);
    check("R2", "lineValid without frameValid", gotQ.size(), 0);
  endtask

  task automatic testTruncate();
    doReset();
    lineLimit = 16'd6; frameLimit = 16'd4; enable = 1'b1;
    addExpected(4, 3, 13, 6, 4);
    sendFrame(4, 3, 13);
    compareStream("R4");
  endtask

  task automatic testFullLine();
    doReset();
    lineLimit = 16'd1280; frameLimit = 16'd3; enable = 1'b1;
    addExpected(5, 2, 1280, 1280, 3);
    sendFrame(5, 2, 1280);
    check("R4", "320 words per line", gotQ.size(), 640);
    compareStream("R4");
  endtask

  task automatic testFrameLimit();
    doReset();
    lineLimit = 16'd8; frameLimit = 16'd3; enable = 1'b1;
    addExpected(6, 5, 8, 8, 3);
    sendFrame(6, 5, 8);
    check("R7", "lines beyond limit dropped", gotQ.size(), 4);
    compareStream("R7");
    check("R10", "one frameDone per frame", doneCount, 1);
  endtask

  task automatic testBackpressure();
    doReset();
    lineLimit = 16'd12; frameLimit = 16'd4; enable = 1'b1; readyMode = 1;
    addExpected(10, 3, 12, 12, 4);
    addExpected(11, 3, 12, 12, 4);
    sendFrame(10, 3, 12);
    sendFrame(11, 3, 12);
    readyMode = 0;
    repeat (4) @(negedge clk);
    compareStream("R8");
    check("R8", "no overflow under light stall", overflow, 0);
    check("R10", "frameDone per frame", doneCount, 2);
  endtask

  task automatic testOverflow();
    doReset();
    lineLimit = 16'd16; frameLimit = 16'd2; enable = 1'b1; readyMode = 2;
    sendFrame(12, 1, 16);
    check("R9", "overflow set", overflow, 1);
    check("R9", "held word valid", outValid, 1);
    check("R9", "held word is first word", outData,
          {pix(12, 0, 3), pix(12, 0, 2), pix(12, 0, 1), pix(12, 0, 0)});
    readyMode = 0;
    repeat (4) @(negedge clk);
    check("R9", "only held word delivered", gotQ.size(), 1);
    check("R9", "overflow sticky", overflow, 1);
    doReset();
    check("R9", "overflow cleared by reset", overflow, 0);
  endtask

  task automatic testDisable();
    doReset();
    lineLimit = 16'd8; frameLimit = 16'd5; enable = 1'b1;
    repeat (3) @(negedge clk);
    frameValid = 1'b1;
    repeat (3) @(negedge clk);
    sendLine(7, 0, 8);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    sendLine(7, 1, 8);
    sendLine(7, 2, 8);
    frameValid = 1'b0;
    repeat (10) @(negedge clk);
    addExpected(7, 1, 8, 8, 5);
    addExpected(8, 2, 8, 8, 5);
    sendFrame(8, 2, 8);
    compareStream("R11");
    check("R11", "frameDone only for whole frame", doneCount, 1);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testMidFrameEnable();
    testPartial();
    testTruncate();
    testFullLine();
    testFrameLimit();
    testBackpressure();
    testOverflow();
    testDisable();
    finishRun();
  end

endmodule